// File: doc/BRIEF.md
# 64-bit Integer Execute Unit

This block is the computation step of a five-stage in-order integer pipeline. Each cycle it can take one operation: two 64-bit operands, a 16-bit immediate with a flag that puts the immediate in place of the second operand, a 6-bit fixed shift count and a 5-bit operation code. The work is done combinationally within the cycle. The result, a zero flag, a signed-overflow flag and a register write enable are captured in output registers, so they are presented to the memory stage one clock later.

The operations are add and subtract, each in a form that reports signed overflow and in a wrapping form that never reports it. There is the complete boolean set. There are signed and unsigned less-than compares. There are shifts with a fixed or a register-supplied count. There are two conditional moves, one taken on a zero test and one on a nonzero test. There is an upper-immediate load, and there is address generation for loads and stores. The write enable is how the conditional moves cancel their register write.

Top module: `exu64`

## Requirements
- R1: Outputs are registered with one cycle of latency. `out_valid` is `in_valid` delayed by one clock. While `in_valid` is low, `result`, `zero` and `ovf` keep their last values. Reset clears every output to 0.
- R2: Opcode 0 (add) and opcode 2 (subtract, A minus B) set `ovf` when the true signed result does not fit in 64 bits. Opcode 1 (add) and opcode 3 (subtract) produce the same wrapped sums with `ovf` held at 0.
- R3: Boolean opcodes are 4 AND, 5 OR, 6 XOR, 7 NOR, 8 NAND and 9 XNOR. Opcode 10 returns the bitwise inverse of A, and the second operand has no effect on it.
- R4: When `use_imm` is 1, the immediate replaces B. For opcodes 4 to 9 it is zero-extended. For every other opcode it is sign-extended from bit 15.
- R5: Opcode 11 (signed) and opcode 12 (unsigned) return 1 when A is less than B and 0 otherwise.
- R6: Opcode 13 shifts A left logically, 14 shifts it right logically and 15 shifts it right arithmetically, in each case by `shamt`. B has no effect on these opcodes.
- R7: Opcodes 16, 17 and 18 do the same three shifts, but the count comes from bits 5:0 of B. The upper bits of B are ignored.
- R8: Opcode 19 returns A and sets `wen` only when B is zero. Opcode 20 returns A and sets `wen` only when B is nonzero. Every other opcode sets `wen` whenever the operation is valid.
- R9: Opcode 21 places the immediate in bits 31:16 and clears bits 15:0. It fills bits 63:32 with copies of immediate bit 15. A has no effect on it.
- R10: Opcode 22 returns A plus the sign-extended immediate, whatever the value of `use_imm`, and never sets `ovf`.
- R11: `zero` is 1 exactly when the registered `result` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op | input | 5 | Operation code |
| src_a | input | 64 | First operand / base address |
| src_b | input | 64 | Second operand / variable shift count / move test |
| imm | input | 16 | Instruction immediate |
| use_imm | input | 1 | Substitute the extended immediate for `src_b` |
| shamt | input | 6 | Fixed shift count |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Registered result |
| zero | output | 1 | Result equals zero |
| ovf | output | 1 | Signed overflow from a reporting add or subtract |
| wen | output | 1 | Destination register write enable |

## Verification
The cases most easily missed are at the edges of the operand range. Overflow appears only at the most positive and most negative values, so the stimulus adds one to the largest positive number and subtracts one from the most negative number. Each of these goes through both the reporting and the wrapping form. The variable shifts are driven with counts whose upper bits are set, to show that only the low six bits take effect. The immediate-extension rule is exercised with a negative immediate, once under a logical opcode and once under an arithmetic one.

// File: rtl/exu64.sv
module exu64 #(
  parameter int W   = 64,
  parameter int IW  = 16,
  parameter int OPW = 5,
  localparam int SW = $clog2(W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   src_a,
  input  logic [W-1:0]   src_b,
  input  logic [IW-1:0]  imm,
  input  logic           use_imm,
  input  logic [SW-1:0]  shamt,
  output logic           out_valid,
  output logic [W-1:0]   result,
  output logic           zero,
  output logic           ovf,
  output logic           wen
);

  localparam logic [OPW-1:0] OP_ADD  = 5'd0,  OP_ADDU = 5'd1,  OP_SUB  = 5'd2,  OP_SUBU = 5'd3;
  localparam logic [OPW-1:0] OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_NOR  = 5'd7;
  localparam logic [OPW-1:0] OP_NAND = 5'd8,  OP_XNOR = 5'd9,  OP_NOT  = 5'd10, OP_SLT  = 5'd11;
  localparam logic [OPW-1:0] OP_SLTU = 5'd12, OP_SLL  = 5'd13, OP_SRL  = 5'd14, OP_SRA  = 5'd15;
  localparam logic [OPW-1:0] OP_SLLV = 5'd16, OP_SRLV = 5'd17, OP_SRAV = 5'd18, OP_MOVZ = 5'd19;
  localparam logic [OPW-1:0] OP_MOVN = 5'd20, OP_LUI  = 5'd21, OP_AGEN = 5'd22;

  logic          is_logic, is_sub, is_var, ovf_c, cond_c;
  logic [W-1:0]  sext_imm, zext_imm, opb, addend, sum, agen, res_c;
  logic [SW-1:0] amt;

  assign is_logic = (op >= OP_AND) && (op <= OP_XNOR);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBU);
  assign is_var   = (op == OP_SLLV) || (op == OP_SRLV) || (op == OP_SRAV);

  assign sext_imm = {{(W-IW){imm[IW-1]}}, imm};
  assign zext_imm = {{(W-IW){1'b0}}, imm};
  assign opb      = use_imm ? (is_logic ? zext_imm : sext_imm) : src_b;

  assign addend = is_sub ? ~opb : opb;
  assign sum    = src_a + addend + {{(W-1){1'b0}}, is_sub};
  assign agen   = src_a + sext_imm;
  assign ovf_c  = ((op == OP_ADD) || (op == OP_SUB)) &&
                  (src_a[W-1] == addend[W-1]) && (sum[W-1] != src_a[W-1]);

  assign amt = is_var ? opb[SW-1:0] : shamt;

  always_comb begin
    cond_c = 1'b1;
    if (op == OP_MOVZ) cond_c = (opb == '0);
    if (op == OP_MOVN) cond_c = (opb != '0);
  end

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU,
      OP_SUB, OP_SUBU:   res_c = sum;
      OP_AND:            res_c = src_a & opb;
      OP_OR:             res_c = src_a | opb;
      OP_XOR:            res_c = src_a ^ opb;
      OP_NOR:            res_c = ~(src_a | opb);
      OP_NAND:           res_c = ~(src_a & opb);
      OP_XNOR:           res_c = ~(src_a ^ opb);
      OP_NOT:            res_c = ~src_a;
      OP_SLT:            res_c = {{(W-1){1'b0}}, $signed(src_a) < $signed(opb)};
      OP_SLTU:           res_c = {{(W-1){1'b0}}, src_a < opb};
      OP_SLL, OP_SLLV:   res_c = src_a << amt;
      OP_SRL, OP_SRLV:   res_c = src_a >> amt;
      OP_SRA, OP_SRAV:   res_c = $signed(src_a) >>> amt;
      OP_MOVZ, OP_MOVN:  res_c = src_a;
      OP_LUI:            res_c = {{(W-2*IW){imm[IW-1]}}, imm, {IW{1'b0}}};
      OP_AGEN:           res_c = agen;
      default:           res_c = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      zero      <= 1'b0;
      ovf       <= 1'b0;
      wen       <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wen       <= in_valid && cond_c;
      if (in_valid) begin
        result <= res_c;
        zero   <= (res_c == '0);
        ovf    <= ovf_c;
      end
    end
  end

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> out_valid == $past(in_valid));
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_ADDU || op == OP_SUBU) |=> !ovf);
  p_cmp_bool_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == OP_SLT || op == OP_SLTU) |=> result[W-1:1] == '0);
  p_movz_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_MOVZ && !use_imm |=> wen == ($past(src_b) == '0));
  p_upper_low_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_LUI |=> result[IW-1:0] == '0);
  p_agen_no_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && op == OP_AGEN |=> !ovf);
  p_zero_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> zero == (result == '0));

endmodule

// File: tb/tb_exu64.sv
module tb_exu64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [15:0] imm = '0;
  logic        use_imm = 1'b0;
  logic [5:0]  shamt = '0;
  logic        out_valid, zero, ovf, wen;
  logic [63:0] result;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exu64 dut (.clk, .rst_n, .in_valid, .op, .src_a, .src_b, .imm, .use_imm, .shamt,
             .out_valid, .result, .zero, .ovf, .wen);

  localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  task automatic check(string req, logic [63:0] r, logic o, logic w);
    logic z = (r == 0);
    checks++;
    if (!out_valid || result !== r || zero !== z || ovf !== o || wen !== w) begin
      fails++;
      $display("FAIL %s: got v=%0b res=%h z=%0b o=%0b w=%0b, expected v=1 res=%h z=%0b o=%0b w=%0b",
               req, out_valid, result, zero, ovf, wen, r, z, o, w);
    end
  endtask

  task automatic run(string req, logic [4:0] c, logic [63:0] a, logic [63:0] b,
                     logic [15:0] im, logic ui, logic [5:0] sh,
                     logic [63:0] r, logic o = 1'b0, logic w = 1'b1);
    @(negedge clk);
    op = c; src_a = a; src_b = b; imm = im; use_imm = ui; shamt = sh; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, r, o, w);
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 0 || result !== 0 || zero !== 0 || ovf !== 0 || wen !== 0) begin
      fails++;
      $display("FAIL R1 reset: got v=%0b res=%h z=%0b o=%0b w=%0b, expected all 0",
               out_valid, result, zero, ovf, wen);
    end
  endtask

  task automatic t_hold;
    run("R1 load", 5'd1, 64'd40, 64'd2, 0, 0, 0, 64'd42);
    @(negedge clk);
    op = 5'd6; src_a = 64'h55; src_b = 64'h55;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || wen !== 0 || result !== 64'd42 || zero !== 0) begin
      fails++;
      $display("FAIL R1 hold: got v=%0b w=%0b res=%h z=%0b, expected v=0 w=0 res=%h z=0",
               out_valid, wen, result, zero, 64'd42);
    end
  endtask

  task automatic t_addsub;
    run("R2 add ovf",    5'd0, MAXP, 64'd1, 0, 0, 0, MINN, 1'b1);
    run("R2 addu wrap",  5'd1, MAXP, 64'd1, 0, 0, 0, MINN, 1'b0);
    run("R2 sub ovf",    5'd2, MINN, 64'd1, 0, 0, 0, MAXP, 1'b1);
    run("R2 subu wrap",  5'd3, MINN, 64'd1, 0, 0, 0, MAXP, 1'b0);
    run("R2 add neg",    5'd0, ONES, ONES, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0);
    run("R2 sub small",  5'd2, 64'd5, 64'd3, 0, 0, 0, 64'd2, 1'b0);
  endtask

  task automatic t_logic;
    run("R3 and",  5'd4, 64'hC, 64'hA, 0, 0, 0, 64'h8);
    run("R3 or",   5'd5, 64'hC, 64'hA, 0, 0, 0, 64'hE);
    run("R3 xor",  5'd6, 64'hC, 64'hA, 0, 0, 0, 64'h6);
    run("R3 nor",  5'd7, 64'hC, 64'hA, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF1);
    run("R3 nand", 5'd8, 64'hC, 64'hA, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF7);
    run("R3 xnor", 5'd9, 64'hC, 64'hA, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF9);
    run("R3 not b=0",    5'd10, 64'hC, 64'h0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF3);
    run("R3 not b=ones", 5'd10, 64'hC, ONES,  0, 0, 0, 64'hFFFF_FFFF_FFFF_FFF3);
  endtask

  task automatic t_imm;
    run("R4 andi zext", 5'd4, ONES, 64'h0, 16'h8001, 1, 0, 64'h8001);
    run("R4 ori zext",  5'd5, 64'h0, ONES, 16'hFFFF, 1, 0, 64'hFFFF);
    run("R4 addi sext", 5'd0, 64'h0, 64'h0, 16'hFFFF, 1, 0, ONES);
    run("R4 subi sext", 5'd2, 64'h0, 64'h0, 16'hFFFF, 1, 0, 64'd1);
  endtask

  task automatic t_slt;
    run("R5 slt neg",   5'd11, ONES, 64'd1, 0, 0, 0, 64'd1);
    run("R5 sltu big",  5'd12, ONES, 64'd1, 0, 0, 0, 64'd0);
    run("R5 slti",      5'd11, 64'd3, 64'd0, 16'h0005, 1, 0, 64'd1);
    run("R5 sltiu sext",5'd12, 64'd3, 64'd0, 16'hFFFF, 1, 0, 64'd1);
    run("R5 slt equal", 5'd11, 64'd7, 64'd7, 0, 0, 0, 64'd0);
  endtask

  task automatic t_fixed_shift;
    run("R6 sll 63", 5'd13, 64'd1, 64'd5, 0, 0, 6'd63, MINN);
    run("R6 srl 4",  5'd14, MINN, 64'd5, 0, 0, 6'd4, 64'h0800_0000_0000_0000);
    run("R6 sra 4",  5'd15, MINN, 64'd5, 0, 0, 6'd4, 64'hF800_0000_0000_0000);
  endtask

  task automatic t_var_shift;
    run("R7 sllv low6", 5'd16, 64'd1, 64'h41, 0, 0, 6'd9, 64'd2);
    run("R7 srav zero", 5'd18, MINN, 64'hFFFF_FFFF_FFFF_FFC0, 0, 0, 6'd9, MINN);
    run("R7 srlv 8",    5'd17, 64'h100, 64'd8, 0, 0, 6'd3, 64'd1);
    run("R7 srav 63",   5'd18, MINN, 64'h3F, 0, 0, 6'd0, ONES);
  endtask

  task automatic t_cmov;
    run("R8 movz taken",   5'd19, 64'h1234, 64'd0, 0, 0, 0, 64'h1234, 1'b0, 1'b1);
    run("R8 movz skipped", 5'd19, 64'h1234, 64'd7, 0, 0, 0, 64'h1234, 1'b0, 1'b0);
    run("R8 movn taken",   5'd20, 64'h99,   64'd7, 0, 0, 0, 64'h99,   1'b0, 1'b1);
    run("R8 movn skipped", 5'd20, 64'h99,   64'd0, 0, 0, 0, 64'h99,   1'b0, 1'b0);
  endtask

  task automatic t_lui;
    run("R9 lui neg", 5'd21, ONES, 64'd0, 16'h8001, 1, 0, 64'hFFFF_FFFF_8001_0000);
    run("R9 lui pos", 5'd21, ONES, 64'd0, 16'h1234, 0, 0, 64'h0000_0000_1234_0000);
  endtask

  task automatic t_agen;
    run("R10 agen neg off", 5'd22, 64'h1000, ONES, 16'hFFF0, 0, 0, 64'hFF0);
    run("R10 agen no ovf",  5'd22, MAXP, 64'd0, 16'h0001, 1, 0, MINN, 1'b0);
  endtask

  task automatic t_zero;
    run("R11 xor self", 5'd6, 64'hDEAD, 64'hDEAD, 0, 0, 0, 64'd0);
    run("R11 addu wrap to zero", 5'd1, ONES, 64'd1, 0, 0, 0, 64'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_hold();
    t_addsub();
    t_logic();
    t_imm();
    t_slt();
    t_fixed_shift();
    t_var_shift();
    t_cmov();
    t_lui();
    t_agen();
    t_zero();
    finish_run();
  end
endmodule